// File: doc/BRIEF.md
# Four-Channel E1 Bit-Doubling Backplane Multiplexer

This block merges four 2.048 Mbit/s E1 payload streams into a single 16.384 Mbit/s serial stream for a high-speed backplane. It runs from a free-running serial clock at eight times the E1 rate. Each channel keeps its 32 timeslot bytes per frame in a byte buffer outside the block. The block asks each channel's buffer for the next byte one serial period before that channel's slot starts. It captures the byte into a private holding register, then shifts it out most significant bit first. Every bit is sent twice in a row.

The stream is ordered by timeslot, then by channel. Timeslot N of channel 0 is sent first, then channels 1, 2 and 3, and then timeslot N+1 starts again with channel 0. One frame is 2048 serial periods long. A one-period frame sync marks the first period of timeslot 0 of channel 0. Indicator outputs give the timeslot and channel being sent.

Data changes just after the rising clock edge, so a downstream receiver samples it on the falling edge. To serve channels 4 to 7, a second copy of the block is used.

Top module: `e1_quad_bitmux`

## Requirements
- R1: While reset is asserted, and for the first 2048 serial periods after it is released, `ser_o`, `fsync_o`, `ts_o` and `ch_o` are all 0. Output begins with serial period 2048 after release, which is the first frame boundary.
- R2: One frame is 2048 periods. `ts_o` gives the timeslot being sent. It holds for 64 periods, then steps by one, and after 31 it wraps to 0.
- R3: Within a timeslot, the channels follow the fixed order 0, 1, 2, 3. Each channel occupies 16 consecutive periods, and `ch_o` gives the channel being sent.
- R4: Each payload bit is driven for two consecutive serial periods.
- R5: At offset k (0 to 15) within a channel slot, `ser_o` carries bit 7 − k/2 of that channel's byte for that timeslot. Bit 7 is sent first.
- R6: `fsync_o` is high for exactly one period per frame. That period is the first copy of bit 7 of timeslot 0 of channel 0.
- R7: In the last period before channel c's slot, `fetch_stb_o` equals the one-hot value with bit c set and `fetch_ts_o` gives that slot's timeslot. `fetch_stb_o` is 0 in all other periods. The byte on lane c of `fetch_data_i` (bits 8c+7 down to 8c) is captured at the clock edge that ends that period.
- R8: A change of `fetch_data_i` after the capture edge has no effect on the bits of the slot being sent.
- R9: An asynchronous reset asserted in mid-frame forces the outputs to the R1 state at once. After release, the R1 startup sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running serial clock, one period per output bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_data_i | input | 32 | Byte lanes from the four channel buffers, lane c at bits 8c+7:8c |
| fetch_stb_o | output | 4 | One-hot byte capture strobe, bit c for channel c |
| fetch_ts_o | output | 5 | Timeslot number whose byte is being requested |
| ser_o | output | 1 | Serial backplane data |
| fsync_o | output | 1 | Frame-start marker, one period wide |
| ts_o | output | 5 | Timeslot currently being sent |
| ch_o | output | 2 | Channel currently being sent |

## Verification
Two things are hard to reach from the ports: a buffer byte that changes in the middle of the slot that carries it, and a byte that changes in the very period it is captured. The stimulus handles both by writing the buffer model at chosen phases of each slot. In late frames it inverts the byte of the slot in progress five periods into the slot. It also rewrites the next slot's byte in the capture period itself. The expected stream must then show the just-written value and never the inverted one. A reset asserted in the middle of a frame, after several frames with different data patterns, covers the restart path.

// File: rtl/e1bm_pkg.sv
package e1bm_pkg;

  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_NUM_TS = 32;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_REPEAT = 2;

  typedef enum logic {
    MX_PRIME = 1'b0,
    MX_RUN   = 1'b1
  } mux_state_e;

endpackage

// File: rtl/e1bm_pos_counter.sv
module e1bm_pos_counter
  import e1bm_pkg::*;
#(
  parameter int unsigned POS_W = 11,
  parameter int unsigned TS_W  = 5,
  parameter int unsigned CH_W  = 2,
  parameter int unsigned LOW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos_o,
  output logic [TS_W-1:0]  nxt_ts_o,
  output logic [CH_W-1:0]  nxt_ch_o,
  output mux_state_e       state_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  mux_state_e       state_q, state_d;
  logic             cnt_en;
  logic             frame_last;

  assign cnt_en     = 1'b1;
  assign frame_last = &pos_q;

  always_comb begin
    pos_d   = pos_q;
    state_d = state_q;
    if (cnt_en) begin
      pos_d = pos_q + POS_W'(1);
      if (frame_last) state_d = MX_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      state_q <= MX_PRIME;
    end else begin
      pos_q   <= pos_d;
      state_q <= state_d;
    end
  end

  assign pos_o    = pos_q;
  assign nxt_ts_o = pos_d[POS_W-1 -: TS_W];
  assign nxt_ch_o = pos_d[LOW_W +: CH_W];
  assign state_o  = state_q;

  // R1: the first pass through the frame is silent; running begins at wrap
  p_run_at_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MX_PRIME && pos_q != '1) |=> (state_q == MX_PRIME));

  // R2: the position wraps to zero after the last period of a frame
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '1) |=> (pos_q == '0 && state_q == MX_RUN));

endmodule

// File: rtl/e1bm_slot_hold.sv
module e1bm_slot_hold #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_end_i,
  input  logic [CH_W-1:0]          nxt_ch_i,
  input  logic [NUM_CH*BYTE_W-1:0] fetch_data_i,
  output logic [NUM_CH-1:0]        fetch_stb_o,
  output logic [NUM_CH*BYTE_W-1:0] hold_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic              ld;
    logic [BYTE_W-1:0] hold_q, hold_d;

    assign ld = slot_end_i && (nxt_ch_i == CH_W'(c));

    always_comb begin
      hold_d = hold_q;
      if (ld) hold_d = fetch_data_i[c*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else        hold_q <= hold_d;
    end

    assign fetch_stb_o[c]               = ld;
    assign hold_o[c*BYTE_W +: BYTE_W] = hold_q;

    // R8: a lane's held byte only changes at its own capture edge
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_stb_o[c] |=> $stable(hold_o[c*BYTE_W +: BYTE_W]));
  end

endmodule

// File: rtl/e1bm_bit_select.sv
module e1bm_bit_select #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned BI_W   = 3
) (
  input  logic [NUM_CH*BYTE_W-1:0] hold_i,
  input  logic [CH_W-1:0]          ch_i,
  input  logic [BI_W-1:0]          bidx_i,
  input  logic                     run_i,
  output logic                     ser_o
);

  logic [BYTE_W-1:0] byte_sel;
  logic [BI_W-1:0]   bit_pos;

  always_comb begin
    byte_sel = hold_i[ch_i*BYTE_W +: BYTE_W];
    bit_pos  = BI_W'(BYTE_W - 1) - bidx_i;
    ser_o    = run_i ? byte_sel[bit_pos] : 1'b0;
  end

endmodule

// File: rtl/e1_quad_bitmux.sv
module e1_quad_bitmux
  import e1bm_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned NUM_TS = DEF_NUM_TS,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned REPEAT = DEF_REPEAT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH*BYTE_W-1:0]     fetch_data_i,
  output logic [NUM_CH-1:0]            fetch_stb_o,
  output logic [$clog2(NUM_TS)-1:0]    fetch_ts_o,
  output logic                         ser_o,
  output logic                         fsync_o,
  output logic [$clog2(NUM_TS)-1:0]    ts_o,
  output logic [$clog2(NUM_CH)-1:0]    ch_o
);

  localparam int unsigned TS_W   = $clog2(NUM_TS);
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned BI_W   = $clog2(BYTE_W);
  localparam int unsigned RP_W   = $clog2(REPEAT);
  localparam int unsigned SLOT_W = BI_W + RP_W;
  localparam int unsigned POS_W  = TS_W + CH_W + SLOT_W;

  logic [POS_W-1:0]         pos;
  logic [TS_W-1:0]          nxt_ts;
  logic [CH_W-1:0]          nxt_ch;
  mux_state_e               state;
  logic                     run;
  logic                     slot_end;
  logic [NUM_CH*BYTE_W-1:0] hold;

  e1bm_pos_counter #(
    .POS_W (POS_W),
    .TS_W  (TS_W),
    .CH_W  (CH_W),
    .LOW_W (SLOT_W)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_o    (pos),
    .nxt_ts_o (nxt_ts),
    .nxt_ch_o (nxt_ch),
    .state_o  (state)
  );

  assign run      = (state == MX_RUN);
  assign slot_end = &pos[SLOT_W-1:0];

  e1bm_slot_hold #(
    .NUM_CH (NUM_CH),
    .BYTE_W (BYTE_W),
    .CH_W   (CH_W)
  ) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_end_i   (slot_end),
    .nxt_ch_i     (nxt_ch),
    .fetch_data_i (fetch_data_i),
    .fetch_stb_o  (fetch_stb_o),
    .hold_o       (hold)
  );

  e1bm_bit_select #(
    .NUM_CH (NUM_CH),
    .BYTE_W (BYTE_W),
    .CH_W   (CH_W),
    .BI_W   (BI_W)
  ) u_sel (
    .hold_i (hold),
    .ch_i   (pos[SLOT_W +: CH_W]),
    .bidx_i (pos[RP_W +: BI_W]),
    .run_i  (run),
    .ser_o  (ser_o)
  );

  assign fetch_ts_o = nxt_ts;
  assign fsync_o    = run && (pos == '0);
  assign ts_o       = run ? pos[POS_W-1 -: TS_W] : '0;
  assign ch_o       = run ? pos[SLOT_W +: CH_W] : '0;

  // R1: nothing leaves the block before running starts
  p_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!ser_o && !fsync_o && ts_o == '0 && ch_o == '0));

  // R2: timeslot steps by one after the last channel slot
  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (&pos[POS_W-TS_W-1:0]) && ts_o != TS_W'(NUM_TS - 1))
    |=> (ts_o == $past(ts_o) + TS_W'(1)));

  // R4: a bit is held across its repeat copies
  p_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(&pos[RP_W-1:0])) |=> (ser_o == $past(ser_o)));

  // R6: frame marker lasts one period
  p_fsync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |=> !fsync_o);

  // R6: frame marker follows the capture of timeslot 0 for channel 0
  p_fsync_after_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> ($past(fetch_stb_o[0]) && $past(fetch_ts_o) == '0));

  // R7: at most one lane captures in any period
  p_fetch_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_stb_o));

endmodule

// File: tb/e1_quad_bitmux_tb_top.sv
module e1_quad_bitmux_tb_top;

  localparam int FRAME = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_data;
  logic [3:0]  fetch_stb;
  logic [4:0]  fetch_ts;
  logic        ser;
  logic        fsync;
  logic [4:0]  ts;
  logic [1:0]  ch;

  logic [7:0]  mem [4][32];
  logic [7:0]  snap [4];

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  int fill_cnt = 0;
  bit second = 0;
  bit done   = 0;
  logic prev_ser = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_buf
    assign fetch_data[g*8 +: 8] = mem[g][fetch_ts];
  end

  e1_quad_bitmux dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_data_i (fetch_data),
    .fetch_stb_o  (fetch_stb),
    .fetch_ts_o   (fetch_ts),
    .ser_o        (ser),
    .fsync_o      (fsync),
    .ts_o         (ts),
    .ch_o         (ch)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d n=%0d", tag, what, act, exp, n);
    end
  endtask

  task automatic fill_frame();
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 32; t++) begin
        case (fill_cnt)
          0:       mem[c][t] = {c[1:0], t[4:0], 1'b1};
          1:       mem[c][t] = 8'hFF;
          2:       mem[c][t] = 8'h00;
          3:       mem[c][t] = 8'hA5 ^ 8'(c);
          default: mem[c][t] = 8'($urandom);
        endcase
      end
    end
    fill_cnt++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      n = 0;
      chk(second ? "R9" : "R1", "ser_in_reset", int'(ser), 0);
      chk(second ? "R9" : "R1", "fsync_in_reset", int'(fsync), 0);
      chk(second ? "R9" : "R1", "ts_in_reset", int'(ts), 0);
      chk(second ? "R9" : "R1", "ch_in_reset", int'(ch), 0);
    end else begin
      int p, q, ets, ech, bi, estb;
      string stag;
      p = n % FRAME;
      q = (n + 1) % FRAME;
      if (n < FRAME) begin
        stag = second ? "R9" : "R1";
        chk(stag, "ser_silent", int'(ser), 0);
        chk(stag, "fsync_silent", int'(fsync), 0);
        chk(stag, "ts_silent", int'(ts), 0);
        chk(stag, "ch_silent", int'(ch), 0);
      end else begin
        ets = p / 64;
        ech = (p / 16) % 4;
        bi  = (p % 16) / 2;
        stag = (fill_cnt > 4) ? "R8" : "R5";
        chk(stag, "ser", int'(ser), int'(snap[ech][7 - bi]));
        chk("R2", "ts", int'(ts), ets);
        chk("R3", "ch", int'(ch), ech);
        chk("R6", "fsync", int'(fsync), (p == 0) ? 1 : 0);
        if (p % 2 == 1) chk("R4", "repeat", int'(ser), int'(prev_ser));
      end
      prev_ser = ser;
      estb = (q % 16 == 0) ? (1 << ((q / 16) % 4)) : 0;
      chk("R7", "fetch_stb", int'(fetch_stb), estb);
      chk("R7", "fetch_ts", int'(fetch_ts), q / 64);

      // stimulus, applied after the checks of this period
      if (p == FRAME - 8) fill_frame();
      if (fill_cnt > 4 && n >= FRAME) begin
        if (p % 16 == 5) mem[(p / 16) % 4][p / 64] = ~mem[(p / 16) % 4][p / 64];
        if (p % 16 == 15) mem[(q / 16) % 4][q / 64] = 8'($urandom);
      end

      // model of the capture at the coming edge
      if (q % 16 == 0) snap[(q / 16) % 4] = mem[(q / 16) % 4][q / 64];
      n++;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      snap[c] = 8'h00;
      for (int t = 0; t < 32; t++) mem[c][t] = 8'h00;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (n == 7 * FRAME + 700);
    @(posedge clk);
    #1 second = 1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (n == 2 * FRAME + 400);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule